// File: doc/BRIEF.md
# Text Display RAM Pointer with Read Prefetch

This block keeps the character-code store for a four-row, twenty-column text display together with the pointer that addresses it and a one-byte staging register. A host interface sends commands on a request stream. Each command either loads the pointer, writes one character code, or reads one. After every write or read the pointer steps by one position, forward or backward as the `step_up` input selects. The rows are not contiguous in the address space: each row owns twenty locations, and the rows start 20H apart. The pointer therefore jumps across the unused gap between rows, and it wraps between the last row and the first.

Reads are pipelined. A read returns whatever the staging register already holds. The block then refills that register from the location the pointer has just moved to. Loading the pointer also refills it. A write puts its byte into the staging register as well as into the store. A status byte reports the pointer and a busy flag. While busy is high the block takes no new command.

Request stream rules: a command transfers on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while busy is high or while a read result waits on the response stream. A read result stays on `rsp_data`, with `rsp_valid` high and the data unchanged, until the host accepts it with `rsp_ready`.

Top module: `dispram_ptr`

## Requirements
- R1: After reset the pointer is 00H, busy is low, `rsp_valid` is low and `req_ready` is high.
- R2: Command code 0 (set) loads the pointer from `req_data[6:0]` when that address lies in a row window. Row windows are 00H-13H, 20H-33H, 40H-53H and 60H-73H, with the row in bits 6:5 and the column in bits 4:0.
- R3: A set address whose column is 14H or more moves to column 0 of the next row. Addresses 74H-7FH move to 00H.
- R4: With `step_up` high, a read or write adds one to the pointer. Column 13H goes to column 0 of the next row, and 73H goes to 00H.
- R5: With `step_up` low, a read or write subtracts one from the pointer. Column 0 goes to column 13H of the previous row, and 00H goes to 73H.
- R6: Command code 1 (write) stores `req_data` at the pointer address, loads the same byte into the staging register, and then steps the pointer.
- R7: Command code 2 (read) returns the staging register on `rsp_data` and steps the pointer. The staging register is then refilled from the new pointer address. A set command also refills it from the loaded address.
- R8: Every accepted command with code 0, 1 or 2 drives busy high for exactly 2 cycles after its accepting edge, and `req_ready` stays low meanwhile. Code 3 is accepted, changes nothing and does not raise busy.
- R9: `stat_byte` carries busy on bit 7 and the pointer on bits 6:0.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high, `rsp_data` holds its value and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_up | input | 1 | 1 steps the pointer forward after access, 0 backward |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Block can take a command |
| req_op | input | 2 | 0 set, 1 write, 2 read, 3 no operation |
| req_data | input | 8 | Address (bits 6:0) for set, character code for write |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Host takes the read result |
| rsp_data | output | 8 | Read result |
| busy | output | 1 | Internal operation in progress |
| stat_byte | output | 8 | {busy, pointer} |

## Verification
The assertions assume that `req_valid`, `req_op`, `req_data`, `step_up` and `rsp_ready` are known after reset. They also assume that a command is presented only through the ready handshake, so no command arrives while busy is high. The bench drives every input on falling edges and starts each command only after it has seen `req_ready` high. It holds `rsp_ready` low only in the back-pressure test. It changes `step_up` only between commands, which keeps the pointer model and the step direction in agreement on every accepting edge.

// File: rtl/dispram_pkg.sv
package dispram_pkg;
  typedef enum logic [1:0] {
    OP_SET = 2'd0,
    OP_WR  = 2'd1,
    OP_RD  = 2'd2,
    OP_NOP = 2'd3
  } op_e;
endpackage

// File: rtl/dispram_addr_unit.sv
module dispram_addr_unit #(
  parameter int LINES = 4,
  parameter int COLS  = 20,
  localparam int LB = $clog2(LINES),
  localparam int CB = $clog2(COLS),
  localparam int AW = LB + CB
) (
  input  logic [AW-1:0] cur,
  input  logic          up,
  input  logic [AW-1:0] raw,
  output logic [AW-1:0] nxt,
  output logic [AW-1:0] fit
);
  localparam logic [LB-1:0] LAST_LINE = LB'(LINES - 1);
  localparam logic [CB-1:0] LAST_COL  = CB'(COLS - 1);

  logic [LB-1:0] line, rline;
  logic [CB-1:0] col, rcol;

  assign line  = cur[AW-1:CB];
  assign col   = cur[CB-1:0];
  assign rline = raw[AW-1:CB];
  assign rcol  = raw[CB-1:0];

  always_comb begin
    if (up) begin
      if (col == LAST_COL) begin
        if (line == LAST_LINE) nxt = '0;
        else                   nxt = {line + 1'b1, {CB{1'b0}}};
      end else begin
        nxt = cur + 1'b1;
      end
    end else begin
      if (col == '0) begin
        if (line == '0) nxt = {LAST_LINE, LAST_COL};
        else            nxt = {line - 1'b1, LAST_COL};
      end else begin
        nxt = cur - 1'b1;
      end
    end
  end

  always_comb begin
    if (rcol > LAST_COL) begin
      if (rline == LAST_LINE) fit = '0;
      else                    fit = {rline + 1'b1, {CB{1'b0}}};
    end else begin
      fit = raw;
    end
  end
endmodule

// File: rtl/dispram_store.sv
module dispram_store #(
  parameter int LINES = 4,
  parameter int COLS  = 20,
  parameter int DW    = 8,
  localparam int LB    = $clog2(LINES),
  localparam int CB    = $clog2(COLS),
  localparam int AW    = LB + CB,
  localparam int DEPTH = LINES * COLS,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  function automatic logic [IW-1:0] to_index(input logic [AW-1:0] a);
    return IW'(a[AW-1:CB]) * IW'(COLS) + IW'(a[CB-1:0]);
  endfunction

  always_ff @(posedge clk) begin
    if (we) mem[to_index(waddr)] <= wdata;
  end

  assign rdata = mem[to_index(raddr)];
endmodule

// File: rtl/dispram_busy.sv
module dispram_busy #(
  parameter int CYCLES = 2,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R8: a started operation shows busy on the next cycle
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R8: the count never exceeds its load value
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CYCLES));
endmodule

// File: rtl/dispram_ptr.sv
module dispram_ptr
  import dispram_pkg::*;
#(
  parameter int LINES       = 4,
  parameter int COLS        = 20,
  parameter int DW          = 8,
  parameter int BUSY_CYCLES = 2,
  localparam int LB = $clog2(LINES),
  localparam int CB = $clog2(COLS),
  localparam int AW = LB + CB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_up,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [DW-1:0] req_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic [AW:0]   stat_byte
);
  localparam logic [LB-1:0] LAST_LINE = LB'(LINES - 1);
  localparam logic [CB-1:0] LAST_COL  = CB'(COLS - 1);

  logic [AW-1:0] ac, ac_nxt, ac_fit;
  logic [DW-1:0] dr, rd_byte;
  logic          pf_pend, acc, start, we;
  op_e           op;

  assign op        = op_e'(req_op);
  assign req_ready = !busy && !rsp_valid;
  assign acc       = req_valid && req_ready;
  assign start     = acc && (op != OP_NOP);
  assign we        = acc && (op == OP_WR);
  assign stat_byte = {busy, ac};

  dispram_addr_unit #(.LINES(LINES), .COLS(COLS)) u_addr (
    .cur(ac), .up(step_up), .raw(req_data[AW-1:0]), .nxt(ac_nxt), .fit(ac_fit)
  );

  dispram_store #(.LINES(LINES), .COLS(COLS), .DW(DW)) u_store (
    .clk(clk), .we(we), .waddr(ac), .wdata(req_data), .raddr(ac), .rdata(rd_byte)
  );

  dispram_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac        <= '0;
      dr        <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      pf_pend   <= 1'b0;
    end else begin
      pf_pend <= 1'b0;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (pf_pend) dr <= rd_byte;
      if (acc) begin
        case (op)
          OP_SET: begin
            ac      <= ac_fit;
            pf_pend <= 1'b1;
          end
          OP_WR: begin
            dr <= req_data;
            ac <= ac_nxt;
          end
          OP_RD: begin
            rsp_valid <= 1'b1;
            rsp_data  <= dr;
            ac        <= ac_nxt;
            pf_pend   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R8: no command accepted while busy
  p_ready_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R8: code 3 leaves pointer and busy untouched
  p_nop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_NOP) |=> (!busy && $stable(ac)));
  // R2 R3: pointer always inside a row window
  p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ac[CB-1:0] <= LAST_COL);
  // R4: forward wrap from last location
  p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == OP_WR || op == OP_RD) && step_up && ac == {LAST_LINE, LAST_COL})
      |=> ac == '0);
  // R5: backward wrap from first location
  p_wrap_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == OP_WR || op == OP_RD) && !step_up && ac == '0)
      |=> ac == {LAST_LINE, LAST_COL});
  // R10: held result under back-pressure
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R7: a read returns the staging register as it stood
  p_rd_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_RD) |=> rsp_data == $past(dr));
endmodule

// File: tb/test_dispram_ptr.sv
module test_dispram_ptr;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_up = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = 2'd0;
  logic [7:0] req_data = 8'd0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       busy;
  logic [7:0] stat_byte;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [6:0] ac_m = 7'h00;
  logic [7:0] dr_m = 8'h00;
  logic [7:0] mem_m [128];
  logic [7:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dispram_ptr i_dispram_ptr (
    .clk(clk), .rst_n(rst_n), .step_up(step_up),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .stat_byte(stat_byte)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] m_up(input logic [6:0] a);
    int l = a / 32;
    int c = a % 32;
    if (c == 19) return (l == 3) ? 7'h00 : 7'((l + 1) * 32);
    return a + 7'd1;
  endfunction

  function automatic logic [6:0] m_dn(input logic [6:0] a);
    int l = a / 32;
    int c = a % 32;
    if (c == 0) return (l == 0) ? 7'h73 : 7'((l - 1) * 32 + 19);
    return a - 7'd1;
  endfunction

  function automatic logic [6:0] m_fit(input logic [6:0] a);
    int l = a / 32;
    int c = a % 32;
    if (c >= 20) return (l == 3) ? 7'h00 : 7'((l + 1) * 32);
    return a;
  endfunction

  function automatic logic [6:0] m_step(input logic [6:0] a);
    return step_up ? m_up(a) : m_dn(a);
  endfunction

  // Scoreboard monitor: compares each accepted read result.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected read result", rsp_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rsp_data == e, "R7 read data", rsp_data, e);
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] d, input string tag,
                       input bit chk_busy = 1'b1);
    @(negedge clk);
    for (int w = 0; w < 50 && !req_ready; w++) @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_data  = d;
    case (op)
      2'd0: begin ac_m = m_fit(d[6:0]); dr_m = mem_m[ac_m]; end
      2'd1: begin mem_m[ac_m] = d; dr_m = d; ac_m = m_step(ac_m); end
      2'd2: begin exp_q.push_back(dr_m); ac_m = m_step(ac_m); dr_m = mem_m[ac_m]; end
      default: ;
    endcase
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    check(stat_byte[6:0] == ac_m, tag, stat_byte[6:0], ac_m);
    if (op == 2'd3) begin
      check(busy == 1'b0 && req_ready == 1'b1, "R8 code 3 leaves busy low", busy, 0);
    end else begin
      check(stat_byte[7] == 1'b1, "R9 busy on status bit 7", stat_byte[7], 1);
      if (chk_busy) begin
        @(negedge clk);
        check(busy == 1'b1 && req_ready == 1'b0, "R8 busy second cycle", busy, 1);
        @(negedge clk);
        check(busy == 1'b0 && req_ready == 1'b1, "R8 busy ends after 2 cycles", busy, 0);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) mem_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(stat_byte == 8'h00, "R1 reset pointer and busy", stat_byte, 0);
    check(rsp_valid == 1'b0, "R1 reset rsp_valid", rsp_valid, 0);
    check(req_ready == 1'b1, "R1 reset req_ready", req_ready, 1);

    // R2 legal set, R4 row jump on write
    issue(2'd0, 8'h13, "R2 set to 13H");
    issue(2'd1, 8'h41, "R4 write at 13H jumps to 20H");
    check(stat_byte[6:0] == 7'h20, "R4 pointer after row end", stat_byte[6:0], 'h20);

    // R6 fill the whole store, R4 wrap 73H -> 00H
    issue(2'd0, 8'h00, "R2 set to 00H");
    for (int i = 0; i < 80; i++) issue(2'd1, 8'(i * 3 + 7), "R6 R4 write step forward");
    check(stat_byte[6:0] == 7'h00, "R4 wrap to 00H after full pass", stat_byte[6:0], 0);

    // R7 reads with prefetch, forward
    issue(2'd0, 8'h11, "R2 set to 11H");
    for (int i = 0; i < 5; i++) issue(2'd2, 8'h00, "R7 R4 read step forward");

    // R5 backward stepping
    step_up = 1'b0;
    issue(2'd0, 8'h21, "R2 set to 21H");
    for (int i = 0; i < 3; i++) issue(2'd2, 8'h00, "R5 read step backward across row");
    issue(2'd0, 8'h00, "R2 set to 00H");
    issue(2'd2, 8'h00, "R5 wrap 00H to 73H");
    check(stat_byte[6:0] == 7'h73, "R5 pointer after backward wrap", stat_byte[6:0], 'h73);
    issue(2'd1, 8'hC4, "R5 R6 write at 73H steps back");
    issue(2'd2, 8'h00, "R7 read after write returns written byte");
    step_up = 1'b1;

    // R3 clamping
    issue(2'd0, 8'h14, "R3 14H clamps to 20H");
    issue(2'd0, 8'h3F, "R3 3FH clamps to 40H");
    issue(2'd0, 8'h55, "R3 55H clamps to 60H");
    issue(2'd0, 8'h7A, "R3 7AH clamps to 00H");
    issue(2'd2, 8'h00, "R3 R7 prefetch from clamped address");

    // R7 write then read: staging register holds written byte
    issue(2'd0, 8'h30, "R2 set to 30H");
    issue(2'd1, 8'h99, "R6 write at 30H");
    issue(2'd2, 8'h00, "R7 read returns staged write");
    issue(2'd2, 8'h00, "R7 read after refill");

    // R8 code 3
    issue(2'd3, 8'h55, "R8 code 3 pointer unchanged");

    // R10 back-pressure
    rsp_ready = 1'b0;
    issue(2'd2, 8'h00, "R10 read under back-pressure", 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(rsp_valid == 1'b1, "R10 rsp_valid held", rsp_valid, 1);
      check(rsp_data == exp_q[0], "R10 rsp_data stable", rsp_data, exp_q[0]);
      check(req_ready == 1'b0, "R10 req_ready low while result waits", req_ready, 0);
    end
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R10 result taken", rsp_valid, 0);
    issue(2'd2, 8'h00, "R7 read after back-pressure");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7 all reads answered", exp_q.size(), 0);
    finish_run();
  end
endmodule